// File: doc/BRIEF.md
# Block-Bounded Serial Pattern Detector

This block watches a serial bit stream, one bit per accepted cycle, and raises a single-cycle hit flag whenever the bit sequence 1, 1, 0, 1 has just arrived, oldest bit first. The stream is cut into fixed blocks of 256 accepted bits, and an occurrence may not straddle two blocks. A position counter tracks where the current bit sits inside its block. At each block boundary it forces the pattern recognizer back to its empty state.

Bits arrive with a valid strobe. The block can take a bit on every cycle, so it never applies back-pressure and there is no ready output. A cycle with the strobe low is simply absent from the stream: neither the counter nor the recognizer moves, and both flags stay low. The hit flag and the block-end flag are Mealy outputs. Each one refers to the bit that is on the input in that same cycle.

Top module: `pdet_block_matcher`

## Requirements
- R1: After a synchronous reset, the position is 0 and the recognizer holds no partial match. The first accepted bit after reset is bit 0 of a block, and no hit can occur until three further qualifying bits have been accepted.
- R2: `hit` is high in the same cycle as an accepted bit 1 when the three bits accepted just before it in the same block were 1, 1, 0, in that order.
- R3: Detection overlaps. The trailing 1 of a match counts as the first bit of the next candidate, so the sequence 1101101 gives two hits.
- R4: An accepted 1 that arrives after two or more consecutive 1s keeps the two-ones progress, so 11101 gives one hit on its last bit.
- R5: An accepted 0 that arrives after a lone 1, or after 110, discards all progress.
- R6: On a cycle with `in_valid` low, `hit` and `block_last` are low, and neither the block position nor the partial match changes.
- R7: `block_last` is high for exactly the accepted bit at position 255 of each block, and low on every other cycle.
- R8: An occurrence whose final bit is at position 255 is reported.
- R9: No hit is reported for an occurrence that spans a block boundary. The return to the empty state at the wrap overrides the data bit at position 255.
- R10: The position counts accepted bits modulo 256. It wraps from 255 to 0, so blocks follow each other back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A stream bit is present this cycle |
| in_bit | input | 1 | The stream bit |
| hit | output | 1 | The pattern ends on this cycle's bit |
| block_last | output | 1 | This cycle's bit is the last one of its block |

## Verification
The hardest case to reach from the ports is a partial match that is one bit short when a block wraps. To get there, the stream must first be walked through an exact count of accepted bits, with idle gaps in between. The bench fills the block with zeros until the position sits just below the boundary. It then places 1, 1, 0 at the end of the block and a 1 at position 0 of the next, and in a separate run places the whole pattern so that it ends on position 255. A long pseudo-random stream with random gaps then crosses several boundaries against the reference model.

// File: rtl/pdet_pkg.sv
package pdet_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_ONE   = 2'd1,
    ST_TWO   = 2'd2,
    ST_THREE = 2'd3
  } pdet_state_e;
endpackage

// File: rtl/pdet_pos_counter.sv
module pdet_pos_counter #(
  parameter int BLOCK_BITS = 256,
  localparam int POS_W = $clog2(BLOCK_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [POS_W-1:0] pos,
  output logic             wrap
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLOCK_BITS - 1);

  logic [POS_W-1:0] pos_q;

  assign wrap = step && (pos_q == LAST_POS);
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (step) begin
      if (wrap) pos_q <= '0;
      else      pos_q <= pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/pdet_recognizer.sv
module pdet_recognizer
  import pdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  logic        bit_i,
  input  logic        clear,
  output logic        found,
  output logic [1:0]  state_o
);
  pdet_state_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      ST_EMPTY: st_d = bit_i ? ST_ONE   : ST_EMPTY;
      ST_ONE:   st_d = bit_i ? ST_TWO   : ST_EMPTY;
      ST_TWO:   st_d = bit_i ? ST_TWO   : ST_THREE;
      ST_THREE: st_d = bit_i ? ST_ONE   : ST_EMPTY;
      default:  st_d = ST_EMPTY;
    endcase
  end

  assign found   = step && bit_i && (st_q == ST_THREE);
  assign state_o = st_q;

  always_ff @(posedge clk) begin
    if (rst)        st_q <= ST_EMPTY;
    else if (step) begin
      if (clear)    st_q <= ST_EMPTY;
      else          st_q <= st_d;
    end
  end
endmodule

// File: rtl/pdet_block_matcher.sv
module pdet_block_matcher #(
  parameter int BLOCK_BITS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic hit,
  output logic block_last
);
  localparam int POS_W = $clog2(BLOCK_BITS);

  logic [POS_W-1:0] pos_q;
  logic [1:0]       st_q;
  logic             wrap;

  pdet_pos_counter #(.BLOCK_BITS(BLOCK_BITS)) u_pos (
    .clk  (clk),
    .rst  (rst),
    .step (in_valid),
    .pos  (pos_q),
    .wrap (wrap)
  );

  pdet_recognizer u_rec (
    .clk     (clk),
    .rst     (rst),
    .step    (in_valid),
    .bit_i   (in_bit),
    .clear   (wrap),
    .found   (hit),
    .state_o (st_q)
  );

  assign block_last = wrap;
endmodule

// File: rtl/pdet_block_matcher_chk.sv
module pdet_block_matcher_chk #(
  parameter int BLOCK_BITS = 256,
  localparam int POS_W = $clog2(BLOCK_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_bit,
  input logic             hit,
  input logic             block_last,
  input logic [POS_W-1:0] pos,
  input logic [1:0]       st
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLOCK_BITS - 1);

  p_hit_on_one_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> (in_valid && in_bit));

  p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!hit && !block_last));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(pos) && $stable(st)));

  p_last_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    block_last |-> (pos == LAST_POS));

  p_wrap_clears_r9: assert property (@(posedge clk) disable iff (rst)
    block_last |=> (pos == '0 && st == 2'd0 && !hit));

  p_pos_advance_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !block_last) |=> (pos == $past(pos) + POS_W'(1)));
endmodule

bind pdet_block_matcher pdet_block_matcher_chk #(.BLOCK_BITS(BLOCK_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_bit     (in_bit),
  .hit        (hit),
  .block_last (block_last),
  .pos        (pos_q),
  .st         (st_q)
);

// File: tb/tb_pdet_block_matcher.sv
module tb_pdet_block_matcher;
  localparam int BLK = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic hit, block_last;

  int checks = 0;
  int fails = 0;
  int pos_m = 0;
  bit hist[$];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  pdet_block_matcher #(.BLOCK_BITS(BLK)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .hit(hit), .block_last(block_last)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at pos %0d: actual=%b expected=%b", tag, what, pos_m, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input string tag);
    logic eh, el;
    @(negedge clk);
    rst = 1'b0; in_valid = v; in_bit = b;
    #1;
    eh = v && b && hist.size() >= 3 &&
         hist[hist.size()-3] && hist[hist.size()-2] && !hist[hist.size()-1];
    el = v && (pos_m == BLK - 1);
    check(tag, "hit", hit, eh);
    check(el ? "R7" : tag, "block_last", block_last, el);
    if (v) begin
      if (pos_m == BLK - 1) begin
        pos_m = 0;
        hist.delete();
      end else begin
        pos_m++;
        hist.push_back(b);
        if (hist.size() > 3) void'(hist.pop_front());
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pos_m = 0;
    hist.delete();
  endtask

  task automatic send(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(1'b1, bits[i], tag);
  endtask

  task automatic fill_to(input int target, input string tag);
    while (pos_m != target) step(1'b1, 1'b0, tag);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    step(1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    fill_to(0, "R1");
    send(16'b1101, 4, "R2");
    repeat (3) step(1'b0, 1'b1, "R6");
    send(16'b0000000_1101101, 7, "R3");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, "R6"); step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, "R6"); step(1'b0, 1'b1, "R6");
    step(1'b1, 1'b0, "R6"); step(1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, "R6");
    step(1'b1, 1'b0, "R4");
    send(16'b11101, 5, "R4");
    step(1'b1, 1'b0, "R5");
    send(16'b1011001101, 10, "R5");
    send(16'b1101001101, 10, "R5");
    fill_to(BLK - 4, "R10");
    send(16'b1101, 4, "R8");
    fill_to(BLK - 3, "R10");
    send(16'b1101, 4, "R9");
    fill_to(BLK - 2, "R10");
    send(16'b1101, 4, "R9");
    for (int i = 0; i < 900; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'd0, lfsr[7] | lfsr[5], "R10");
    end
    fill_to(100, "R10");
    do_reset();
    step(1'b0, 1'b0, "R1");
    fill_to(BLK - 1, "R1");
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule